// File: doc/BRIEF.md
# Calendar Time-of-Year Counter

This block keeps wall-clock time as second, minute, hour, day of month, month and year. A tick-enable input strobes at 32768 Hz. A prescaler of `PRESC_W` bits (15 by default) divides it into a one-second step, and each step carries through the calendar fields. Months have their real lengths, and February has 29 days in years divisible by four.

Software reaches the block through a 32-bit word register port. The time of day and the date share one packed word, and the year has a register of its own. A shared control word gates the calendar. Reads and writes of the time registers have effect only while two control bits are both set. The prescaler and the calendar also hold still while the calendar is gated off.

The request side is a valid/ready channel. `req_ready` is tied high, so every request is taken in the cycle it is presented. A read answers in the next cycle with a one-cycle `rsp_valid` pulse, and the response side cannot be stalled. A write produces no response.

Top module: `tod_calendar`

## Requirements
- R1: After reset the control word at offset 0x40 reads 0, and the time and year registers read 0. When the calendar is then enabled, it reads day 1, month 1, 00:00:00 and year 0.
- R2: The calendar is on only when control bit 11 and control bit 8 are both 1. The control word stores all 32 written bits and reads them back at 0x40.
- R3: While the calendar is off, reads of 0x2C and 0x30 return 0. Writes to 0x24 and 0x28 change nothing, and no tick advances the prescaler or the calendar.
- R4: The time word is packed as month[31:26] (1-based, January = 1), day[25:21], hour[20:16], minute[15:10], second[9:4] and sub-second[3:0]. A write to 0x24 loads all five calendar fields at once and clears the prescaler. On a read of 0x2C, the sub-second field shows the top 4 bits of the prescaler.
- R5: A write to 0x28 loads the year (low `YEAR_W` bits) and leaves the time word unchanged. A read of 0x30 returns the year zero-extended.
- R6: With the calendar on, the second advances once every 2^PRESC_W cycles with `tick_en` high. Cycles with `tick_en` low change nothing.
- R7: Seconds and minutes wrap from 59 to 0 with a carry, and hours wrap from 23 to 0 with a carry into the day.
- R8: The day wraps to 1 after the last day of its month: 30 days in April, June, September and November, 31 days in the other months except February.
- R9: February has 29 days when the year is a multiple of 4 and 28 days otherwise.
- R10: Stepping past the last second of December sets month 1 and increments the year.
- R11: `req_ready` is always 1. A read is answered exactly one cycle later by a one-cycle `rsp_valid` pulse carrying the value at the request cycle. Writes give no `rsp_valid`. Unmapped offsets and the set-time offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32768 Hz tick enable |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench sweeps all twelve months over a common year, a leap year and year 2100. For each month it sets the last second of the second-to-last day and of the last day. A wrong month-length table, or a leap rule other than divisible-by-four, would land on the wrong day or month. A year that fails to carry at December would stay unchanged.

A run of one hour and one minute, read every second, crosses many minute wraps, an hour wrap and midnight into a new month. An off-by-one in any wrap limit would show up as a skipped or repeated value.

Other runs check the following:
- Writes and ticks while each enable bit is cleared alone. A design gated by a single bit would let them through.
- The sub-second field partway through a second. A prescaler not cleared on load would shift the whole second.
- Year writes alone. A shared load would corrupt the time word.

// File: rtl/tod_cal_pkg.sv
package tod_cal_pkg;

  localparam logic [7:0] OFF_SET_TIME = 8'h24;
  localparam logic [7:0] OFF_SET_YEAR = 8'h28;
  localparam logic [7:0] OFF_GET_TIME = 8'h2C;
  localparam logic [7:0] OFF_GET_YEAR = 8'h30;
  localparam logic [7:0] OFF_CTRL     = 8'h40;

  localparam int CTRL_CAL_BIT = 11;
  localparam int CTRL_OSC_BIT = 8;

  // Field order matches bits [31:4] of the packed time word.
  typedef struct packed {
    logic [5:0] month;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] minute;
    logic [5:0] second;
  } cal_fields_t;

  function automatic logic [4:0] month_length(input logic [5:0] month, input logic leap);
    logic [4:0] len;
    case (month)
      6'd2:                       len = leap ? 5'd29 : 5'd28;
      6'd4, 6'd6, 6'd9, 6'd11:    len = 5'd30;
      default:                    len = 5'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/tod_cal_prescale.sv
module tod_cal_prescale #(
  parameter int PRESC_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               clear,
  output logic [PRESC_W-1:0] count,
  output logic               sec_stb
);
  localparam logic [PRESC_W-1:0] LAST = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear)      cnt_q <= '0;
    else if (run && tick) cnt_q <= cnt_q + 1'b1;
  end

  assign count   = cnt_q;
  assign sec_stb = run && tick && !clear && (cnt_q == LAST);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && tick) && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/tod_cal_core.sv
module tod_cal_core
  import tod_cal_pkg::*;
#(
  parameter int YEAR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load_time,
  input  cal_fields_t       time_in,
  input  logic              load_year,
  input  logic [YEAR_W-1:0] year_in,
  output cal_fields_t       now,
  output logic [YEAR_W-1:0] year
);
  localparam cal_fields_t RESET_FIELDS = '{month: 6'd1, day: 5'd1, hour: 5'd0,
                                           minute: 6'd0, second: 6'd0};

  cal_fields_t       cur_q, nxt;
  logic [YEAR_W-1:0] year_q, nyear;
  logic              leap;
  logic [4:0]        mlen;

  assign leap = (year_q[1:0] == 2'b00);
  assign mlen = month_length(cur_q.month, leap);

  always_comb begin
    nxt   = cur_q;
    nyear = year_q;
    if (step) begin
      if (cur_q.second >= 6'd59) begin
        nxt.second = 6'd0;
        if (cur_q.minute >= 6'd59) begin
          nxt.minute = 6'd0;
          if (cur_q.hour >= 5'd23) begin
            nxt.hour = 5'd0;
            if (cur_q.day >= mlen) begin
              nxt.day = 5'd1;
              if (cur_q.month >= 6'd12) begin
                nxt.month = 6'd1;
                nyear     = year_q + 1'b1;
              end else begin
                nxt.month = cur_q.month + 6'd1;
              end
            end else begin
              nxt.day = cur_q.day + 5'd1;
            end
          end else begin
            nxt.hour = cur_q.hour + 5'd1;
          end
        end else begin
          nxt.minute = cur_q.minute + 6'd1;
        end
      end else begin
        nxt.second = cur_q.second + 6'd1;
      end
    end
    if (load_time) nxt   = time_in;
    if (load_year) nyear = year_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= RESET_FIELDS;
      year_q <= '0;
    end else begin
      cur_q  <= nxt;
      year_q <= nyear;
    end
  end

  assign now  = cur_q;
  assign year = year_q;

  assert_frozen_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_time && !load_year) |=> ($stable(cur_q) && $stable(year_q)));

  assert_sec_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_time && cur_q.second == 6'd59) |=> (cur_q.second == 6'd0));

  assert_year_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_time && !load_year && cur_q.month == 6'd12 && cur_q.day == 5'd31 &&
     cur_q.hour == 5'd23 && cur_q.minute == 6'd59 && cur_q.second == 6'd59)
    |=> (cur_q.month == 6'd1 && cur_q.day == 5'd1 && year_q == $past(year_q) + 1'b1));

  assert_year_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_year && !load_time && !step) |=> $stable(cur_q));

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_cal_pkg::*;
#(
  parameter int PRESC_W = 15,
  parameter int YEAR_W  = 16,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int SUB_W = 4;

  logic [31:0]        ctrl_q;
  logic               cal_on;
  logic               wr, rd;
  logic               hit_set_time, hit_set_year, hit_get_time, hit_get_year, hit_ctrl;
  logic               load_time, load_year;
  logic [PRESC_W-1:0] presc;
  logic               sec_stb;
  cal_fields_t        now;
  logic [YEAR_W-1:0]  year;
  logic [31:0]        rd_mux;

  assign req_ready = 1'b1;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  assign hit_set_time = (req_addr == ADDR_W'(OFF_SET_TIME));
  assign hit_set_year = (req_addr == ADDR_W'(OFF_SET_YEAR));
  assign hit_get_time = (req_addr == ADDR_W'(OFF_GET_TIME));
  assign hit_get_year = (req_addr == ADDR_W'(OFF_GET_YEAR));
  assign hit_ctrl     = (req_addr == ADDR_W'(OFF_CTRL));

  assign cal_on    = ctrl_q[CTRL_CAL_BIT] && ctrl_q[CTRL_OSC_BIT];
  assign load_time = wr && hit_set_time && cal_on;
  assign load_year = wr && hit_set_year && cal_on;

  always_ff @(posedge clk) begin
    if (!rst_n)             ctrl_q <= '0;
    else if (wr && hit_ctrl) ctrl_q <= req_wdata;
  end

  tod_cal_prescale #(.PRESC_W(PRESC_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cal_on),
    .tick    (tick_en),
    .clear   (load_time),
    .count   (presc),
    .sec_stb (sec_stb)
  );

  tod_cal_core #(.YEAR_W(YEAR_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (sec_stb),
    .load_time (load_time),
    .time_in   (cal_fields_t'(req_wdata[31:4])),
    .load_year (load_year),
    .year_in   (req_wdata[YEAR_W-1:0]),
    .now       (now),
    .year      (year)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)                  rd_mux = ctrl_q;
    else if (hit_get_time && cal_on) rd_mux = {now, presc[PRESC_W-1 -: SUB_W]};
    else if (hit_get_year && cal_on) rd_mux = 32'(year);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  assert_rsp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  assert_no_rsp_otherwise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

  assert_off_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !cal_on && (hit_get_time || hit_get_year)) |=> (rsp_rdata == 32'd0));

  assert_no_load_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_time || load_year) |-> (ctrl_q[CTRL_CAL_BIT] && ctrl_q[CTRL_OSC_BIT]));

  initial assert (PRESC_W >= SUB_W && YEAR_W <= 32);

endmodule

// File: tb/tod_calendar_tb.sv
module tod_calendar_tb;
  localparam int PW = 4;
  localparam int TPS = 1 << PW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  bit reported = 1'b0;

  always #10 clk = ~clk;

  tod_calendar #(.PRESC_W(PW), .YEAR_W(16), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] pk(input int m, input int d, input int h,
                                     input int mi, input int s, input int ss);
    return {m[5:0], d[4:0], h[4:0], mi[5:0], s[5:0], ss[3:0]};
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m < 8)  return 30 + (m & 1);
    return 31 - (m & 1);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h40, d, v); chk("R1 ctrl", d, 32'h0);
    rd(8'h2C, d, v); chk("R1 time", d, 32'h0);
    rd(8'h30, d, v); chk("R1 year", d, 32'h0);
    wr(8'h40, 32'h0000_0900);
    rd(8'h2C, d, v); chk("R1 time after enable", d, pk(1, 1, 0, 0, 0, 0));

    // R2 control readback, R11 handshake
    wr(8'h40, 32'hA5A5_5B5A);
    rd(8'h40, d, v); chk("R2 ctrl readback", d, 32'hA5A5_5B5A); chk("R11 rsp_valid", {31'd0, v}, 32'd1);
    @(negedge clk); chk("R11 rsp pulse one cycle", {31'd0, rsp_valid}, 32'd0);
    chk("R11 ready", {31'd0, req_ready}, 32'd1);
    wr(8'h40, 32'h0000_0900);
    chk("R11 no rsp on write", {31'd0, rsp_valid}, 32'd0);
    rd(8'h50, d, v); chk("R11 unmapped", d, 32'h0);
    rd(8'h24, d, v); chk("R11 set-time reads zero", d, 32'h0);

    // R4 load and layout, R5 year
    wr(8'h24, pk(7, 19, 13, 42, 8, 0));
    wr(8'h28, 32'd1999);
    rd(8'h2C, d, v); chk("R4 time load", d, pk(7, 19, 13, 42, 8, 0));
    rd(8'h30, d, v); chk("R5 year load", d, 32'd1999);
    wr(8'h28, 32'd2031);
    rd(8'h2C, d, v); chk("R5 time untouched by year", d, pk(7, 19, 13, 42, 8, 0));
    rd(8'h30, d, v); chk("R5 year readback", d, 32'd2031);

    // R6 prescaler and sub-second
    repeat (40) @(negedge clk);
    rd(8'h2C, d, v); chk("R6 no tick holds", d, pk(7, 19, 13, 42, 8, 0));
    ticks(5);
    rd(8'h2C, d, v); chk("R4 sub-second", d, pk(7, 19, 13, 42, 8, 5));
    ticks(TPS - 6);
    rd(8'h2C, d, v); chk("R6 last tick of second", d, pk(7, 19, 13, 42, 8, TPS - 1));
    ticks(1);
    rd(8'h2C, d, v); chk("R6 second step", d, pk(7, 19, 13, 42, 9, 0));
    ticks(3);
    wr(8'h24, pk(7, 19, 13, 42, 20, 9));
    rd(8'h2C, d, v); chk("R4 load clears prescaler", d, pk(7, 19, 13, 42, 20, 0));

    // R3 gating by each bit alone
    for (int g = 0; g < 2; g++) begin
      wr(8'h40, g == 0 ? 32'h0000_0800 : 32'h0000_0100);
      rd(8'h2C, d, v); chk("R3 time reads zero", d, 32'h0);
      rd(8'h30, d, v); chk("R3 year reads zero", d, 32'h0);
      wr(8'h24, pk(3, 3, 3, 3, 3, 0));
      wr(8'h28, 32'd77);
      ticks(3 * TPS);
      wr(8'h40, 32'h0000_0900);
      rd(8'h2C, d, v); chk("R3 time not written or advanced", d, pk(7, 19, 13, 42, 20, 0));
      rd(8'h30, d, v); chk("R3 year not written", d, 32'd2031);
    end

    // R8 R9 R10 month sweep
    foreach (d[i]) if (i < 3) begin
      int y;
      y = (i == 0) ? 2023 : (i == 1) ? 2024 : 2100;
      for (int m = 1; m <= 12; m++) begin
        int len;
        len = mdays(m, y);
        wr(8'h28, y);
        wr(8'h24, pk(m, len - 1, 23, 59, 59, 0));
        ticks(TPS);
        rd(8'h2C, d, v); chk(m == 2 ? "R9 day before month end" : "R8 day before month end", d, pk(m, len, 0, 0, 0, 0));
        wr(8'h24, pk(m, len, 23, 59, 59, 0));
        ticks(TPS);
        rd(8'h2C, d, v);
        chk(m == 2 ? "R9 month end" : (m == 12 ? "R10 month end" : "R8 month end"), d, pk(m == 12 ? 1 : m + 1, 1, 0, 0, 0, 0));
        rd(8'h30, d, v); chk("R10 year", d, m == 12 ? y + 1 : y);
      end
    end

    // R7 long run across minute, hour and midnight wraps
    wr(8'h28, 32'd7);
    wr(8'h24, pk(1, 31, 22, 59, 30, 0));
    for (int k = 1; k <= 3660; k++) begin
      int t, dd, mm;
      ticks(TPS);
      t = 82770 + k; dd = 31; mm = 1;
      if (t >= 86400) begin t -= 86400; dd = 1; mm = 2; end
      rd(8'h2C, d, v);
      chk("R7 wrap sweep", d, pk(mm, dd, t / 3600, (t / 60) % 60, t % 60, 0));
    end

    report();
  end
endmodule